// File: doc/BRIEF.md
# Tile Pixel Attribute and Priority Mixer

This block produces the final colour choice for one pixel of a tile layer and merges it with a sprite pixel at the same screen position. Each tile carries its own attribute byte. That byte holds a priority flag and two mirror flags. It also holds a flag that makes index zero see-through, and a 4-bit palette select. The block mirrors the in-tile column and row as the flags ask. It picks the pixel's colour index out of the tile's pattern planes and builds a 6-bit palette address from the palette select and those index bits. It then decides whether the tile pixel is see-through.

The mixer then chooses between the tile pixel and the incoming sprite pixel. If a tile pixel is opaque and has its priority flag set, it covers a sprite. Otherwise an opaque sprite covers the tile. If neither layer is opaque, the block raises a backdrop flag. The result is registered, so it appears one clock after the inputs are presented. Pattern and attribute fetch happen upstream; this block only consumes them.

Top module: `tile_prio_mixer`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it rises, the outputs go to `pix_addr_o` = 0 and `backdrop_o` = 1, whatever the other inputs are.
- R2: The outputs reflect the inputs sampled on the previous rising clock edge, so they have exactly one cycle of latency. They do not change between edges.
- R3: The attribute byte `attr_i` is decoded as follows: bit 7 is priority, bit 6 is column mirror, bit 5 is row mirror and bit 4 is zero-transparent. Bits 3:0 are the palette select, with bit 3 as its most significant bit. The pattern bit for plane p, row r and column c is at `pattern_i[p*64 + r*8 + (7-c)]`. Plane 0 is the least significant bit of the pixel index, and column 0 is the leftmost pixel.
- R4: When the column mirror flag is set, the pixel is read from column 7 - `col_i` instead of `col_i`.
- R5: When the row mirror flag is set, the pixel is read from row 7 - `row_i` instead of `row_i`.
- R6: With `depth_i` = 2'b00 (one bit per pixel), the tile address is {`bank_i`, palette select[3:0], plane0}.
- R7: With `depth_i` = 2'b01 (two bits per pixel), the tile address is {palette select[3:0], plane1, plane0}.
- R8: With `depth_i` = 2'b10 or 2'b11 (three bits per pixel), the tile address is {palette select[3:1], plane2, plane1, plane0}.
- R9: When the zero-transparent flag is set, a tile pixel is see-through if the index bits used at the current depth are all zero. Plane bits that the current depth does not use do not count.
- R10: When the zero-transparent flag is clear, the tile pixel is always opaque. Index zero then produces its normal palette address.
- R11: An opaque tile pixel with the priority flag set is output even when the sprite is opaque.
- R12: An opaque sprite (`spr_opaque_i` = 1) is output as `spr_addr_i` when the tile pixel is see-through or its priority flag is clear. An opaque tile pixel is output when the sprite is see-through.
- R13: When both the tile pixel and the sprite are see-through, `backdrop_o` = 1 and `pix_addr_o` = 0, whatever `spr_addr_i` holds. In every other case `backdrop_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| attr_i | input | 8 | Per-tile attribute byte |
| depth_i | input | 2 | Pattern depth: 00 one bit, 01 two bits, 1x three bits |
| bank_i | input | 1 | Global high address bit used at one-bit depth |
| col_i | input | 3 | In-tile column of the pixel |
| row_i | input | 3 | In-tile row of the pixel |
| pattern_i | input | 192 | Three 8x8 pattern planes of the tile |
| spr_opaque_i | input | 1 | Sprite pixel is opaque |
| spr_addr_i | input | 6 | Sprite pixel palette address |
| pix_addr_o | output | 6 | Chosen palette address, registered |
| backdrop_o | output | 1 | Neither layer opaque, registered |

## Verification
The hardest case to reach is a pattern whose index is zero only in the planes the current depth uses, while a higher, unused plane holds a one. Only that case shows whether the see-through test masks by depth. The bench fills the tile from a formula in which the pixel index depends on both row and column. It then picks coordinates where the full 3-bit index is 2 but the one-bit view is 0. The same formula makes every mirror combination land on a different index. As a result, a swapped or missing flip changes the address.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    localparam int TILE_DIM = 8;
    localparam int COORD_W  = $clog2(TILE_DIM);
    localparam int PLANES   = 3;
    localparam int PS_W     = 4;
    localparam int PAL_W    = PS_W + 2;
    localparam int AREA     = TILE_DIM * TILE_DIM;
    localparam int PAT_W    = PLANES * AREA;

    typedef enum logic [1:0] {
        DEPTH_ONE   = 2'b00,
        DEPTH_TWO   = 2'b01,
        DEPTH_THREE = 2'b10,
        DEPTH_THR_B = 2'b11
    } depth_e;

    typedef struct packed {
        logic            pri;
        logic            mir_col;
        logic            mir_row;
        logic            zero_clear;
        logic [PS_W-1:0] pal_sel;
    } tile_attr_t;

    typedef struct packed {
        logic             opaque;
        logic [PAL_W-1:0] addr;
    } layer_pix_t;

    function automatic logic [COORD_W-1:0] mirror_coord(
        input logic [COORD_W-1:0] v,
        input logic               en
    );
        return en ? (COORD_W'(TILE_DIM - 1) - v) : v;
    endfunction

    function automatic logic [PLANES-1:0] depth_mask(input depth_e d);
        case (d)
            DEPTH_ONE: return PLANES'(1);
            DEPTH_TWO: return PLANES'(3);
            default:   return PLANES'(7);
        endcase
    endfunction

endpackage

// File: rtl/tpm_fetch_pix.sv
module tpm_fetch_pix
    import tpm_pkg::*;
(
    input  logic [PAT_W-1:0]   pattern_i,
    input  logic [COORD_W-1:0] col_i,
    input  logic [COORD_W-1:0] row_i,
    input  logic               mir_col_i,
    input  logic               mir_row_i,
    output logic [PLANES-1:0]  pix_val_o
);

    logic [COORD_W-1:0] eff_col;
    logic [COORD_W-1:0] eff_row;
    int                 in_plane;

    always_comb begin
        eff_col  = mirror_coord(col_i, mir_col_i);
        eff_row  = mirror_coord(row_i, mir_row_i);
        in_plane = int'(eff_row) * TILE_DIM + (TILE_DIM - 1 - int'(eff_col));
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        assign pix_val_o[p] = pattern_i[p * AREA + in_plane];
    end

endmodule

// File: rtl/tpm_palgen.sv
module tpm_palgen
    import tpm_pkg::*;
(
    input  logic [PS_W-1:0]   pal_sel_i,
    input  logic              zero_clear_i,
    input  depth_e            depth_i,
    input  logic              bank_i,
    input  logic [PLANES-1:0] pix_val_i,
    output layer_pix_t        tile_o
);

    logic [PLANES-1:0] used_bits;

    always_comb begin
        used_bits = pix_val_i & depth_mask(depth_i);
        case (depth_i)
            DEPTH_ONE: tile_o.addr = {bank_i, pal_sel_i, pix_val_i[0]};
            DEPTH_TWO: tile_o.addr = {pal_sel_i, pix_val_i[1:0]};
            default:   tile_o.addr = {pal_sel_i[PS_W-1:1], pix_val_i[2:0]};
        endcase
        tile_o.opaque = !zero_clear_i || (used_bits != '0);
    end

endmodule

// File: rtl/tpm_mix.sv
module tpm_mix
    import tpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  layer_pix_t       tile_i,
    input  logic             tile_pri_i,
    input  layer_pix_t       spr_i,
    output logic [PAL_W-1:0] pix_addr_o,
    output logic             backdrop_o
);

    logic tile_wins;

    always_comb begin
        tile_wins = tile_i.opaque && (tile_pri_i || !spr_i.opaque);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_addr_o <= '0;
            backdrop_o <= 1'b1;
        end else if (tile_wins) begin
            pix_addr_o <= tile_i.addr;
            backdrop_o <= 1'b0;
        end else if (spr_i.opaque) begin
            pix_addr_o <= spr_i.addr;
            backdrop_o <= 1'b0;
        end else begin
            pix_addr_o <= '0;
            backdrop_o <= 1'b1;
        end
    end

    // R11
    pri_tile_chk: assert property (@(posedge clk) disable iff (rst)
        (tile_i.opaque && tile_pri_i) |=> (pix_addr_o == $past(tile_i.addr)) && !backdrop_o);

    // R12
    spr_over_chk: assert property (@(posedge clk) disable iff (rst)
        (spr_i.opaque && !(tile_i.opaque && tile_pri_i)) |=> (pix_addr_o == $past(spr_i.addr)) && !backdrop_o);

    // R12
    tile_alone_chk: assert property (@(posedge clk) disable iff (rst)
        (tile_i.opaque && !spr_i.opaque) |=> (pix_addr_o == $past(tile_i.addr)));

    // R13
    bkdrop_chk: assert property (@(posedge clk) disable iff (rst)
        (!tile_i.opaque && !spr_i.opaque) |=> backdrop_o && (pix_addr_o == '0));

endmodule

// File: rtl/tile_prio_mixer.sv
module tile_prio_mixer
    import tpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         attr_i,
    input  logic [1:0]         depth_i,
    input  logic               bank_i,
    input  logic [COORD_W-1:0] col_i,
    input  logic [COORD_W-1:0] row_i,
    input  logic [PAT_W-1:0]   pattern_i,
    input  logic               spr_opaque_i,
    input  logic [PAL_W-1:0]   spr_addr_i,
    output logic [PAL_W-1:0]   pix_addr_o,
    output logic               backdrop_o
);

    tile_attr_t        attr;
    layer_pix_t        tile_pix;
    layer_pix_t        spr_pix;
    logic [PLANES-1:0] pix_val;

    assign attr    = tile_attr_t'(attr_i);
    assign spr_pix = '{opaque: spr_opaque_i, addr: spr_addr_i};

    tpm_fetch_pix u_fetch (
        .pattern_i (pattern_i),
        .col_i     (col_i),
        .row_i     (row_i),
        .mir_col_i (attr.mir_col),
        .mir_row_i (attr.mir_row),
        .pix_val_o (pix_val)
    );

    tpm_palgen u_palgen (
        .pal_sel_i    (attr.pal_sel),
        .zero_clear_i (attr.zero_clear),
        .depth_i      (depth_e'(depth_i)),
        .bank_i       (bank_i),
        .pix_val_i    (pix_val),
        .tile_o       (tile_pix)
    );

    tpm_mix u_mix (
        .clk        (clk),
        .rst        (rst),
        .tile_i     (tile_pix),
        .tile_pri_i (attr.pri),
        .spr_i      (spr_pix),
        .pix_addr_o (pix_addr_o),
        .backdrop_o (backdrop_o)
    );

    // R1
    rst_state_chk: assert property (@(posedge clk)
        rst |=> backdrop_o && (pix_addr_o == '0));

    // R10
    no_zero_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !attr_i[4] |=> !backdrop_o);

    // R13
    bkdrop_addr_chk: assert property (@(posedge clk) disable iff (rst)
        backdrop_o |-> (pix_addr_o == '0));

endmodule

// File: tb/tile_prio_mixer_tb.sv
module tile_prio_mixer_tb_top;

    localparam int NV = 16;
    // fields: attr, depth, col, row, bank, spr_opq, spr_addr, exp_addr, exp_bd, req
    localparam logic [34:0] VECS [NV] = '{
        {8'h0A, 2'b10, 3'd3, 3'd1, 1'b0, 1'b0, 6'h00, 6'h2D, 1'b0, 4'd8},  // R8
        {8'h05, 2'b01, 3'd2, 3'd0, 1'b0, 1'b0, 6'h00, 6'h16, 1'b0, 4'd7},  // R7
        {8'h0C, 2'b00, 3'd1, 3'd0, 1'b1, 1'b0, 6'h00, 6'h39, 1'b0, 4'd6},  // R6
        {8'h43, 2'b10, 3'd1, 3'd0, 1'b0, 1'b0, 6'h00, 6'h0E, 1'b0, 4'd4},  // R4
        {8'h27, 2'b10, 3'd0, 3'd1, 1'b0, 1'b0, 6'h00, 6'h1C, 1'b0, 4'd5},  // R5
        {8'h6F, 2'b10, 3'd2, 3'd3, 1'b0, 1'b0, 6'h00, 6'h3D, 1'b0, 4'd3},  // R3 both mirrors
        {8'h19, 2'b10, 3'd0, 3'd0, 1'b0, 1'b0, 6'h00, 6'h00, 1'b1, 4'd9},  // R9
        {8'h19, 2'b10, 3'd0, 3'd0, 1'b0, 1'b1, 6'h2A, 6'h2A, 1'b0, 4'd12}, // R12
        {8'h09, 2'b10, 3'd0, 3'd0, 1'b0, 1'b0, 6'h00, 6'h20, 1'b0, 4'd10}, // R10
        {8'h86, 2'b01, 3'd3, 3'd0, 1'b0, 1'b1, 6'h15, 6'h1B, 1'b0, 4'd11}, // R11
        {8'h06, 2'b01, 3'd3, 3'd0, 1'b0, 1'b1, 6'h15, 6'h15, 1'b0, 4'd12}, // R12
        {8'h96, 2'b01, 3'd0, 3'd4, 1'b0, 1'b1, 6'h15, 6'h15, 1'b0, 4'd11}, // R11 see-through tile
        {8'h13, 2'b00, 3'd2, 3'd0, 1'b0, 1'b0, 6'h00, 6'h00, 1'b1, 4'd9},  // R9 unused plane set
        {8'h10, 2'b10, 3'd0, 3'd0, 1'b0, 1'b0, 6'h3F, 6'h00, 1'b1, 4'd13}, // R13
        {8'h1F, 2'b01, 3'd1, 3'd1, 1'b0, 1'b0, 6'h00, 6'h3F, 1'b0, 4'd7},  // R7
        {8'h0A, 2'b11, 3'd3, 3'd1, 1'b0, 1'b0, 6'h00, 6'h2D, 1'b0, 4'd8}   // R8 alt code
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   attr_i = '0;
    logic [1:0]   depth_i = '0;
    logic         bank_i = 1'b0;
    logic [2:0]   col_i = '0;
    logic [2:0]   row_i = '0;
    logic [191:0] pattern_i = '0;
    logic         spr_opaque_i = 1'b0;
    logic [5:0]   spr_addr_i = '0;
    logic [5:0]   pix_addr_o;
    logic         backdrop_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tile_prio_mixer dut_i (
        .clk          (clk),
        .rst          (rst),
        .attr_i       (attr_i),
        .depth_i      (depth_i),
        .bank_i       (bank_i),
        .col_i        (col_i),
        .row_i        (row_i),
        .pattern_i    (pattern_i),
        .spr_opaque_i (spr_opaque_i),
        .spr_addr_i   (spr_addr_i),
        .pix_addr_o   (pix_addr_o),
        .backdrop_o   (backdrop_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [5:0] exp_addr, input logic exp_bd);
        checks++;
        if (pix_addr_o !== exp_addr || backdrop_o !== exp_bd) begin
            errors++;
            $display("FAIL %s addr=%0h bd=%0b expected addr=%0h bd=%0b",
                     req, pix_addr_o, backdrop_o, exp_addr, exp_bd);
        end
    endtask

    task automatic apply(input logic [34:0] v);
        attr_i       = v[34:27];
        depth_i      = v[26:25];
        col_i        = v[24:22];
        row_i        = v[21:19];
        bank_i       = v[18];
        spr_opaque_i = v[17];
        spr_addr_i   = v[16:11];
    endtask

    initial begin
        // pixel index at row r, column c is (c + 2r) mod 8; plane 0 is the LSB (R3)
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 8; c++) begin
                for (int p = 0; p < 3; p++) begin
                    pattern_i[p*64 + r*8 + (7-c)] = 1'(((c + 2*r) % 8) >> p);
                end
            end
        end
        apply(VECS[9]);
        @(negedge clk);
        @(negedge clk);
        check("R1 reset state", 6'h00, 1'b1);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", int'(VECS[i][3:0]), i),
                  VECS[i][10:5], VECS[i][4]);
        end

        // R2: output holds until the next edge, then follows the new inputs
        @(negedge clk);
        apply(VECS[0]);
        @(posedge clk);
        @(negedge clk);
        apply(VECS[6]);
        #2;
        check("R2 hold before edge", 6'h2D, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R2 update after edge", 6'h00, 1'b1);

        // R1: reset in mid-run with an opaque priority tile presented
        apply(VECS[9]);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset mid-run", 6'h00, 1'b1);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R11 after reset release", 6'h1B, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule